// File: doc/BRIEF.md
# Modem Terminal-Side Control Timing

This block is the digital sequencer that sits between a data terminal and a low-speed FSK modem core. It turns the terminal's request-to-send into clear-to-send once a selectable wait has elapsed. It qualifies the modem's fast carrier-detect signal with separate turn-on and turn-off delays, and holds received data at mark whenever no carrier is qualified. It also provides a digital loopback test mode and a reference clock divided down from the master clock.

All delays are counted in ticks of the divided reference clock. With the default divide of 4096 from a 3.579545 MHz master clock, one tick is about 1.144 ms. A two-bit timing select picks one of three built-in delay sets, and each set fixes the send delay and both carrier delays together. Select value 3 hands clear-to-send and carrier detect over to external timer inputs. The request, carrier, external-timer and carrier-control inputs are asynchronous, so each passes through two flops before use.

Top module: `dte_ctl_timing`

## Requirements
- R1: `ref_clk` is the master clock divided by 2^DIV_LOG2 (default 4096, about 873.9 Hz) with equal high and low halves, and one delay tick occurs per `ref_clk` period.
- R2: With select 0, 1 or 2 and loopback off, `cts_n` goes low only after `rts_n` has been held low for 350, 26 or 306 ticks respectively (400, 30 and 350 ms rounded to the nearest tick), and it never falls more than one tick period plus four clocks past that count.
- R3: `cts_n` returns high no later than three clocks after `rts_n` goes high, whatever the select value. If `rts_n` goes high before the count completes, the count restarts from zero on the next request.
- R4: A raw carrier high is reported on `cd_out` after an ON delay of 271, 11 or 140 ticks for select 0, 1 or 2. A low blip during the count restarts it.
- R5: A raw carrier low removes `cd_out` after an OFF delay of 39, 39 or 22 ticks for select 0, 1 or 2.
- R6: With select 3, `cts_n` follows `ext_cts_n` and `cd_out` follows `ext_cd` after the two-flop synchronizer, and no internal delay applies.
- R7: Outside loopback, `rxd` equals `rx_demod` while `cd_out` is high, and is forced to mark (1) while `cd_out` is low.
- R8: With `loop_en` high, `rxd` equals `tx_data`, `mod_data` equals `rx_demod`, `cts_n` follows the synchronized `rts_n` with no delay, and `carrier_on` follows the synchronized `cc_n` (active low) instead of `rts_n`. With `loop_en` low, `mod_data` equals `tx_data` and `carrier_on` is the synchronized inverse of `rts_n`.
- R9: During and right after reset, `cts_n` is 1, `cd_out` is 0, `rxd` is 1 and `ref_clk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rts_n | input | 1 | Request to send, active low |
| cd_fast | input | 1 | Raw fast carrier detect, active high |
| rx_demod | input | 1 | Demodulated receive data |
| tx_data | input | 1 | Transmit data from the terminal |
| tsel | input | 2 | Delay set select; 3 selects external timers |
| loop_en | input | 1 | Digital loopback enable |
| cc_n | input | 1 | Carrier control in loopback, active low |
| ext_cts_n | input | 1 | External send-delay timer output, active low |
| ext_cd | input | 1 | External carrier-detect timer output |
| cts_n | output | 1 | Clear to send, active low |
| cd_out | output | 1 | Qualified carrier detect |
| rxd | output | 1 | Received data to the terminal |
| mod_data | output | 1 | Data to the modulator |
| carrier_on | output | 1 | Transmit carrier enable |
| ref_clk | output | 1 | Divided reference clock |

## Verification
The assertions assume that `tsel` and `loop_en` are static configuration. They may change only while the request is off and the carrier timers are idle, because a change in the middle of a count would mix two limits. The bench changes these inputs only between scenarios, after `rts_n` has been high and the raw carrier has been settled for well over a tick. It runs the block with a divide of 8 so that full-length tick counts fit in a short run, and it drives every input on the falling clock edge.

// File: rtl/dte_ctl_timing.sv
module dte_ctl_timing #(
  parameter int DIV_LOG2 = 12,
  parameter int RC_T0 = 350,
  parameter int RC_T1 = 26,
  parameter int RC_T2 = 306,
  parameter int ON_T0 = 271,
  parameter int ON_T1 = 11,
  parameter int ON_T2 = 140,
  parameter int OFF_T0 = 39,
  parameter int OFF_T1 = 39,
  parameter int OFF_T2 = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rts_n,
  input  logic       cd_fast,
  input  logic       rx_demod,
  input  logic       tx_data,
  input  logic [1:0] tsel,
  input  logic       loop_en,
  input  logic       cc_n,
  input  logic       ext_cts_n,
  input  logic       ext_cd,
  output logic       cts_n,
  output logic       cd_out,
  output logic       rxd,
  output logic       mod_data,
  output logic       carrier_on,
  output logic       ref_clk
);
  localparam int MAXT = (RC_T0 > ON_T0) ? RC_T0 : ON_T0;
  localparam int CW = $clog2(MAXT + 1) + 1;
  localparam logic [4:0] SYNC_RST = 5'b10101;

  logic [DIV_LOG2-1:0] div;
  logic [4:0] meta, sync;
  logic rts_s, cdf_s, xcts_s, xcd_s, cc_s;
  logic tick, byp, cts_r, cd_r;
  logic [CW-1:0] rc_cnt, cd_cnt, rc_lim, on_lim, off_lim, cd_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta <= SYNC_RST;
      sync <= SYNC_RST;
    end else begin
      meta <= {rts_n, cd_fast, ext_cts_n, ext_cd, cc_n};
      sync <= meta;
    end
  assign {rts_s, cdf_s, xcts_s, xcd_s, cc_s} = sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else div <= div + 1'b1;
  assign tick = &div;
  assign ref_clk = div[DIV_LOG2-1];

  always_comb begin
    case (tsel)
      2'd1:    begin rc_lim = CW'(RC_T1); on_lim = CW'(ON_T1); off_lim = CW'(OFF_T1); end
      2'd2:    begin rc_lim = CW'(RC_T2); on_lim = CW'(ON_T2); off_lim = CW'(OFF_T2); end
      default: begin rc_lim = CW'(RC_T0); on_lim = CW'(ON_T0); off_lim = CW'(OFF_T0); end
    endcase
  end
  assign cd_lim = cd_r ? off_lim : on_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cts_r <= 1'b1;
      rc_cnt <= '0;
    end else if (rts_s) begin
      cts_r <= 1'b1;
      rc_cnt <= '0;
    end else if (cts_r && tick) begin
      rc_cnt <= rc_cnt + 1'b1;
      if (rc_cnt == rc_lim - 1'b1) cts_r <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cd_r <= 1'b0;
      cd_cnt <= '0;
    end else if (cdf_s == cd_r) begin
      cd_cnt <= '0;
    end else if (tick) begin
      if (cd_cnt == cd_lim - 1'b1) begin
        cd_r <= cdf_s;
        cd_cnt <= '0;
      end else begin
        cd_cnt <= cd_cnt + 1'b1;
      end
    end

  assign byp        = (tsel == 2'd3);
  assign cd_out     = byp ? xcd_s : cd_r;
  assign cts_n      = loop_en ? rts_s : (byp ? xcts_s : cts_r);
  assign rxd        = loop_en ? tx_data : (cd_out ? rx_demod : 1'b1);
  assign mod_data   = loop_en ? rx_demod : tx_data;
  assign carrier_on = loop_en ? ~cc_s : ~rts_s;

  p_cts_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_s && !loop_en && !byp) |=> cts_n);

  p_cts_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cts_r) |-> ($past(tick) && !$past(rts_s)));

  p_cd_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_r != $past(cd_r)) |-> ($past(tick) && $past(cdf_s) == cd_r));

  p_mark_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cd_out && !loop_en) |-> rxd);

  p_bypass_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && !loop_en) |-> (cts_n == xcts_s));

  p_loop_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rxd == tx_data && mod_data == rx_demod));
endmodule

// File: tb/dte_ctl_timing_tb.sv
module dte_ctl_timing_tb;
  localparam int DL = 3;
  localparam int P = 1 << DL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rts_n = 1'b1, cd_fast = 1'b0, rx_demod = 1'b1, tx_data = 1'b1;
  logic [1:0] tsel = 2'd0;
  logic loop_en = 1'b0, cc_n = 1'b1, ext_cts_n = 1'b1, ext_cd = 1'b0;
  logic cts_n, cd_out, rxd, mod_data, carrier_on, ref_clk;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dte_ctl_timing #(.DIV_LOG2(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .rts_n(rts_n), .cd_fast(cd_fast),
    .rx_demod(rx_demod), .tx_data(tx_data), .tsel(tsel), .loop_en(loop_en),
    .cc_n(cc_n), .ext_cts_n(ext_cts_n), .ext_cd(ext_cd), .cts_n(cts_n),
    .cd_out(cd_out), .rxd(rxd), .mod_data(mod_data), .carrier_on(carrier_on),
    .ref_clk(ref_clk));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 cts_n", cts_n, 1'b1);
    chk("R9 cd_out", cd_out, 1'b0);
    chk("R9 rxd", rxd, 1'b1);
    chk("R9 ref_clk", ref_clk, 1'b0);
  endtask

  task automatic t_refclk;
    int hi = 0, lo = 0;
    @(posedge ref_clk); @(negedge clk);
    while (ref_clk) begin hi++; @(negedge clk); end
    while (!ref_clk) begin lo++; @(negedge clk); end
    chk("R1 high half", hi == P / 2, 1'b1);
    chk("R1 low half", lo == P / 2, 1'b1);
  endtask

  task automatic t_cts(input logic [1:0] sel, input int lim);
    tsel = sel;
    cyc(2);
    rts_n = 1'b0;
    chk("R8 carrier_on follows rts_n (normal)", carrier_on, 1'b0);
    cyc((lim - 1) * P - 2);
    chk("R2 cts_n still off before delay", cts_n, 1'b1);
    cyc(P + 6);
    chk("R2 cts_n on after delay", cts_n, 1'b0);
    chk("R8 carrier_on in normal mode", carrier_on, 1'b1);
    rts_n = 1'b1;
    cyc(3);
    chk("R3 cts_n off quickly", cts_n, 1'b1);
    cyc(2);
  endtask

  task automatic t_restart;
    tsel = 2'd1;
    rts_n = 1'b0;
    cyc(20 * P);
    rts_n = 1'b1;
    cyc(3);
    chk("R3 aborted request", cts_n, 1'b1);
    rts_n = 1'b0;
    cyc(25 * P - 2);
    chk("R3 count restarted", cts_n, 1'b1);
    cyc(P + 6);
    chk("R3 cts_n after full restart count", cts_n, 1'b0);
    rts_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_cd(input logic [1:0] sel, input int on_lim, input int off_lim, input bit blip);
    tsel = sel;
    rx_demod = 1'b0;
    cyc(2);
    chk("R7 mark while carrier off", rxd, 1'b1);
    cd_fast = 1'b1;
    if (blip) begin
      cyc((on_lim / 2) * P);
      cd_fast = 1'b0;
      cyc(2);
      cd_fast = 1'b1;
    end
    cyc((on_lim - 1) * P - 2);
    chk("R4 carrier not yet qualified", cd_out, 1'b0);
    cyc(P + 6);
    chk("R4 carrier qualified", cd_out, 1'b1);
    chk("R7 rxd passes space", rxd, 1'b0);
    rx_demod = 1'b1;
    #1 chk("R7 rxd passes mark", rxd, 1'b1);
    rx_demod = 1'b0;
    cd_fast = 1'b0;
    cyc((off_lim - 1) * P - 2);
    chk("R5 carrier held during off delay", cd_out, 1'b1);
    cyc(P + 6);
    chk("R5 carrier dropped", cd_out, 1'b0);
    chk("R7 rxd forced mark after drop", rxd, 1'b1);
    rx_demod = 1'b1;
  endtask

  task automatic t_bypass;
    tsel = 2'd3;
    cyc(2);
    ext_cts_n = 1'b0;
    ext_cd = 1'b1;
    cyc(3);
    chk("R6 cts_n from external timer", cts_n, 1'b0);
    chk("R6 cd_out from external timer", cd_out, 1'b1);
    ext_cts_n = 1'b1;
    ext_cd = 1'b0;
    cyc(3);
    chk("R6 cts_n external off", cts_n, 1'b1);
    chk("R6 cd_out external off", cd_out, 1'b0);
    tsel = 2'd0;
    cyc(2);
  endtask

  task automatic t_loop;
    loop_en = 1'b1;
    tx_data = 1'b0;
    rx_demod = 1'b1;
    #1;
    chk("R8 rxd from tx_data", rxd, 1'b0);
    chk("R8 mod_data from rx_demod", mod_data, 1'b1);
    rx_demod = 1'b0;
    #1 chk("R8 mod_data follows rx_demod", mod_data, 1'b0);
    cyc(1);
    rts_n = 1'b0;
    cyc(3);
    chk("R8 cts_n follows rts_n at once", cts_n, 1'b0);
    chk("R8 carrier_on ignores rts_n", carrier_on, 1'b0);
    cc_n = 1'b0;
    cyc(3);
    chk("R8 carrier_on from cc_n", carrier_on, 1'b1);
    loop_en = 1'b0;
    tx_data = 1'b1;
    #1 chk("R8 mod_data from tx_data normal", mod_data, 1'b1);
    rts_n = 1'b1;
    cc_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    t_refclk();
    t_cts(2'd0, 350);
    t_cts(2'd1, 26);
    t_cts(2'd2, 306);
    t_restart();
    t_cd(2'd0, 271, 39, 1'b0);
    t_cd(2'd1, 11, 39, 1'b1);
    t_cd(2'd2, 140, 22, 1'b0);
    t_bypass();
    t_loop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule